// File: doc/BRIEF.md
# USB IN Endpoint Transfer Sequencer

This block follows one device-side IN endpoint through a transfer made of several packets. Software programs a maximum packet length, a packet count and a total byte count. It then sets the enable bit to arm the endpoint. From then on the block tells the FIFO side the size of the next packet to load. It lowers the byte count as each packet is loaded, and answers each IN token with either a send pulse or a NAK pulse. Each time a transaction outcome arrives, it lowers the packet count by one.

Every packet except the last is a full maximum-length packet. The last packet's size is computed once, when the endpoint is armed, as the total length minus (count − 1) × maximum length. A zero-length packet is requested with a total of 0 and a count of 1. When the final transaction is acknowledged, and no transaction of the transfer has failed, the block raises a transfer-done flag and clears its own enable bit. All events land in write-1-to-clear flags. Each flag has an enable bit, and the enabled flags drive one interrupt line.

The register window has four word addresses:
- 0 is the control word: enable at bit 31, maximum packet length in the low bits.
- 1 holds the interrupt enables.
- 2 is the length word: byte count in bits [18:0], packet count in bits [28:19].
- 3 holds the flags.

Flag bit positions are: 0 ACK, 1 DONE, 2 TXERR, 3 NAK, 4 ERR. The same positions are used for the interrupt enables. Read data appears one cycle after the address is presented.

Top module: `usb_in_ep_seq`

## Requirements
- R1: After reset the control, length, flag and interrupt-enable words read 0, and irq, tx_go and tx_nak are low.
- R2: Writing address 0 with bit 31 set arms the endpoint when the length word is consistent. The control word then reads back bit 31 = 1 and the written maximum length.
- R3: next_pkt_size equals the maximum packet length while more than one packet remains to be loaded. For the last packet it equals total − (count − 1) × maximum, so a count of 1 gives the total length.
- R4: A count of 1 with a total of 0 gives a next_pkt_size of 0. Such a transfer completes with DONE (bit 1) and clears the enable.
- R5: Each packet loaded while enabled lowers the byte count field by the packet's size.
- R6: An IN token while enabled, with a loaded packet, gives a one-cycle tx_go pulse. Each completed transaction lowers the packet count by one, and an ACK outcome sets flag bit 0.
- R7: An IN token while disabled, or with no loaded packet, gives a one-cycle tx_nak pulse and sets flag bit 3. The count fields are left unchanged.
- R8: A completed transaction without ACK sets flag bit 2 and still lowers the packet count. DONE is then not raised when the transfer ends.
- R9: When the last packet's transaction is acknowledged and no transaction of the transfer failed, flag bit 1 is set and the enable bit clears by itself.
- R10: Writing address 0 with bit 31 clear disables the endpoint at once, so the next IN token is NAKed.
- R11: irq is the OR, over all flags, of each flag ANDed with its enable bit at address 1, one cycle after them. Writing 1 to a flag bit at address 3 clears it.
- R12: A loaded packet whose size differs from next_pkt_size sets flag bit 4. Arming with an inconsistent length word also sets flag bit 4 and leaves the endpoint disabled. Inconsistent means a count of 0, a total below (count − 1) × maximum, or a last packet longer than the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| pkt_wr | input | 1 | A packet was loaded into the transmit FIFO |
| pkt_size | input | MPLW | Byte size of the loaded packet |
| next_pkt_size | output | MPLW | Size expected for the next packet to load |
| in_tok | input | 1 | IN token received for this endpoint |
| tx_go | output | 1 | Send the head packet |
| tx_nak | output | 1 | Answer the token with NAK |
| txn_done | input | 1 | Transaction finished on the bus |
| txn_ack | input | 1 | Outcome of that transaction was ACK |
| ep_active | output | 1 | Endpoint enable bit |
| irq | output | 1 | Interrupt request |

## Verification
The main function is tried with several transfer shapes:
- A three-packet transfer with a short last packet, which separates the full-size packets from the remainder.
- A single short packet, which shows that a count of 1 yields the total length.
- A zero-length transfer, which exercises the degenerate remainder.
- A transfer with one failed transaction, which separates the count decrement from the success flag.

Tokens arrive before any packet is loaded, after a software disable, and after normal loading. These three cases tell the NAK path apart from the send path. A mismatched packet size and an inconsistent length word each check the error flag, and the second also checks that arming is refused.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  localparam int NFLAG     = 5;
  localparam int FLG_ACK   = 0;
  localparam int FLG_DONE  = 1;
  localparam int FLG_TXERR = 2;
  localparam int FLG_NAK   = 3;
  localparam int FLG_ERR   = 4;
  localparam int EN_BIT    = 31;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_IEN  = 2'd1,
    A_LEN  = 2'd2,
    A_FLAG = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/usb_in_size_calc.sv
// Last-packet size and consistency check for a length word.
module usb_in_size_calc #(
  parameter int PCW  = 10,
  parameter int TLW  = 19,
  parameter int MPLW = 11
) (
  input  logic [PCW-1:0]  pcnt,
  input  logic [TLW-1:0]  tlen,
  input  logic [MPLW-1:0] mpl,
  output logic [MPLW-1:0] last_sz,
  output logic            bad
);
  localparam int PW = PCW + MPLW;
  localparam int SW = ((TLW > PW) ? TLW : PW) + 1;

  logic [PCW-1:0] pm1;
  logic [PW-1:0]  prod;
  logic [SW-1:0]  diff;

  always_comb begin
    pm1     = pcnt - PCW'(1);
    prod    = PW'(pm1) * PW'(mpl);
    diff    = SW'(tlen) - SW'(prod);
    bad     = (pcnt == '0) || (SW'(prod) > SW'(tlen)) || (diff > SW'(mpl));
    last_sz = diff[MPLW-1:0];
  end
endmodule

// File: rtl/usb_in_xfer_ctrl.sv
// Endpoint state: enable, counters, queued packets, token handling.
module usb_in_xfer_ctrl
  import usb_in_ep_pkg::*;
#(
  parameter int PCW  = 10,
  parameter int TLW  = 19,
  parameter int MPLW = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_ctrl_wr,
  input  logic             sw_len_wr,
  input  logic             w_en,
  input  logic [MPLW-1:0]  w_mpl,
  input  logic [PCW-1:0]   w_pcnt,
  input  logic [TLW-1:0]   w_tlen,
  input  logic             cfg_bad,
  input  logic [MPLW-1:0]  calc_last,
  input  logic             pkt_wr,
  input  logic [MPLW-1:0]  pkt_size,
  input  logic             tok,
  input  logic             txn_done,
  input  logic             txn_ack,
  output logic             en,
  output logic [MPLW-1:0]  mpl,
  output logic [PCW-1:0]   pcnt,
  output logic [TLW-1:0]   tlen,
  output logic [MPLW-1:0]  next_size,
  output logic             tx_go,
  output logic             tx_nak,
  output logic [NFLAG-1:0] ev
);
  logic [MPLW-1:0] last_sz;
  logic [PCW-1:0]  queued;
  logic [PCW-1:0]  rem;
  logic            busy;
  logic            fail;
  logic            wr_ok, tok_go, tok_nak, done_ok, last_done, arm;

  always_comb begin
    rem       = pcnt - queued;
    next_size = (rem == PCW'(1)) ? last_sz : mpl;
    wr_ok     = en && pkt_wr && (rem != '0);
    tok_go    = tok && en && (queued != '0) && !busy;
    tok_nak   = tok && !tok_go;
    done_ok   = txn_done && busy;
    last_done = done_ok && (pcnt == PCW'(1));
    arm       = sw_ctrl_wr && w_en;
    ev                = '0;
    ev[FLG_ACK]       = done_ok && txn_ack;
    ev[FLG_TXERR]     = done_ok && !txn_ack;
    ev[FLG_DONE]      = last_done && txn_ack && !fail;
    ev[FLG_NAK]       = tok_nak;
    ev[FLG_ERR]       = (wr_ok && (pkt_size != next_size)) || (arm && cfg_bad);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      mpl     <= '0;
      pcnt    <= '0;
      tlen    <= '0;
      last_sz <= '0;
      queued  <= '0;
      busy    <= 1'b0;
      fail    <= 1'b0;
      tx_go   <= 1'b0;
      tx_nak  <= 1'b0;
    end else begin
      tx_go  <= tok_go;
      tx_nak <= tok_nak;

      if (sw_len_wr) begin
        pcnt <= w_pcnt;
        tlen <= w_tlen;
      end else begin
        if (wr_ok) begin
          if (TLW'(pkt_size) > tlen) tlen <= '0;
          else                       tlen <= tlen - TLW'(pkt_size);
        end
        if (done_ok) pcnt <= pcnt - PCW'(1);
      end

      if (sw_ctrl_wr) begin
        en  <= w_en && !cfg_bad;
        mpl <= w_mpl;
        if (arm) begin
          last_sz <= calc_last;
          queued  <= '0;
          busy    <= 1'b0;
          fail    <= 1'b0;
        end
      end else begin
        if (last_done) en <= 1'b0;
        case ({wr_ok, done_ok})
          2'b10:   queued <= queued + PCW'(1);
          2'b01:   queued <= queued - PCW'(1);
          default: queued <= queued;
        endcase
        if (tok_go)       busy <= 1'b1;
        else if (done_ok) busy <= 1'b0;
        if (done_ok && !txn_ack) fail <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_in_flags.sv
// Write-1-to-clear status flags, interrupt enables and the interrupt line.
module usb_in_flags
  import usb_in_ep_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ien_wr,
  input  logic             flag_w1c,
  input  logic [NFLAG-1:0] wdata,
  input  logic [NFLAG-1:0] ev,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] ien,
  output logic             irq
);
  logic [NFLAG-1:0] clr;

  always_comb clr = flag_w1c ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      ien   <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr) | ev;
      if (ien_wr) ien <= wdata;
      irq <= |(flags & ien);
    end
  end
endmodule

// File: rtl/usb_in_ep_seq.sv
// Top: register window, size calculation, transfer control and flags.
module usb_in_ep_seq
  import usb_in_ep_pkg::*;
#(
  parameter int PCW  = 10,
  parameter int TLW  = 19,
  parameter int MPLW = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            pkt_wr,
  input  logic [MPLW-1:0] pkt_size,
  output logic [MPLW-1:0] next_pkt_size,
  input  logic            in_tok,
  output logic            tx_go,
  output logic            tx_nak,
  input  logic            txn_done,
  input  logic            txn_ack,
  output logic            ep_active,
  output logic            irq
);
  logic             ctrl_wr, ien_wr, len_wr, flag_w1c;
  logic             ep_en;
  logic [MPLW-1:0]  cur_mpl;
  logic [PCW-1:0]   cur_pcnt;
  logic [TLW-1:0]   cur_tlen;
  logic [MPLW-1:0]  calc_last;
  logic             cfg_bad;
  logic [NFLAG-1:0] ev, flags, ien;
  logic [31:0]      rd_mux;

  always_comb begin
    ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
    ien_wr   = reg_wr && (reg_addr == A_IEN);
    len_wr   = reg_wr && (reg_addr == A_LEN);
    flag_w1c = reg_wr && (reg_addr == A_FLAG);
  end

  usb_in_size_calc #(.PCW(PCW), .TLW(TLW), .MPLW(MPLW)) u_calc (
    .pcnt    (cur_pcnt),
    .tlen    (cur_tlen),
    .mpl     (reg_wdata[MPLW-1:0]),
    .last_sz (calc_last),
    .bad     (cfg_bad)
  );

  usb_in_xfer_ctrl #(.PCW(PCW), .TLW(TLW), .MPLW(MPLW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sw_ctrl_wr (ctrl_wr),
    .sw_len_wr  (len_wr),
    .w_en       (reg_wdata[EN_BIT]),
    .w_mpl      (reg_wdata[MPLW-1:0]),
    .w_pcnt     (reg_wdata[TLW +: PCW]),
    .w_tlen     (reg_wdata[TLW-1:0]),
    .cfg_bad    (cfg_bad),
    .calc_last  (calc_last),
    .pkt_wr     (pkt_wr),
    .pkt_size   (pkt_size),
    .tok        (in_tok),
    .txn_done   (txn_done),
    .txn_ack    (txn_ack),
    .en         (ep_en),
    .mpl        (cur_mpl),
    .pcnt       (cur_pcnt),
    .tlen       (cur_tlen),
    .next_size  (next_pkt_size),
    .tx_go      (tx_go),
    .tx_nak     (tx_nak),
    .ev         (ev)
  );

  usb_in_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .ien_wr   (ien_wr),
    .flag_w1c (flag_w1c),
    .wdata    (reg_wdata[NFLAG-1:0]),
    .ev       (ev),
    .flags    (flags),
    .ien      (ien),
    .irq      (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[EN_BIT]     = ep_en;
        rd_mux[MPLW-1:0]   = cur_mpl;
      end
      A_IEN:  rd_mux[NFLAG-1:0] = ien;
      A_LEN: begin
        rd_mux[TLW-1:0]    = cur_tlen;
        rd_mux[TLW +: PCW] = cur_pcnt;
      end
      default: rd_mux[NFLAG-1:0] = flags;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign ep_active = ep_en;
endmodule

// File: rtl/usb_in_ep_seq_chk.sv
// Property checker attached to the sequencer top.
module usb_in_ep_seq_chk #(
  parameter int PCW = 10,
  parameter int TLW = 19
) (
  input logic           clk,
  input logic           rst,
  input logic           ctrl_wr,
  input logic           len_wr,
  input logic           en,
  input logic [PCW-1:0] pcnt,
  input logic [TLW-1:0] tlen,
  input logic           tx_go,
  input logic           tx_nak
);
  // R7
  go_nak_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_go && tx_nak));

  // R6
  go_when_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    tx_go |-> $past(en));

  // R6
  pcnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(len_wr) |-> ((pcnt == $past(pcnt)) || (pcnt == $past(pcnt) - PCW'(1))));

  // R5
  tlen_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(len_wr) |-> (tlen <= $past(tlen)));

  // R9
  auto_off_last_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(en) && !$past(ctrl_wr)) |-> ($past(pcnt) == PCW'(1)));
endmodule

bind usb_in_ep_seq usb_in_ep_seq_chk #(.PCW(PCW), .TLW(TLW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ctrl_wr (ctrl_wr),
  .len_wr  (len_wr),
  .en      (ep_en),
  .pcnt    (cur_pcnt),
  .tlen    (cur_tlen),
  .tx_go   (tx_go),
  .tx_nak  (tx_nak)
);

// File: tb/tb_usb_in_ep_seq.sv
`timescale 1ns/1ps
module tb_usb_in_ep_seq;
  localparam int PCW = 10, TLW = 19, MPLW = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_wr = 1'b0;
  logic [1:0]      reg_addr = 2'd0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            pkt_wr = 1'b0;
  logic [MPLW-1:0] pkt_size = '0;
  logic [MPLW-1:0] next_pkt_size;
  logic            in_tok = 1'b0;
  logic            tx_go, tx_nak;
  logic            txn_done = 1'b0;
  logic            txn_ack = 1'b0;
  logic            ep_active, irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit exp_q[$];

  always #4 clk = ~clk;

  usb_in_ep_seq #(.PCW(PCW), .TLW(TLW), .MPLW(MPLW)) dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each token response is compared with the queued expectation.
  always @(negedge clk) begin
    if (!rst && (tx_go || tx_nak)) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6: actual=unexpected response expected=none");
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (tx_go !== e) begin
          errors++;
          $display("FAIL %s: actual go=%0b expected go=%0b", e ? "R6" : "R7", tx_go, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1; reg_addr = a;
    @(posedge clk); #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] len_word(input int pc, input int tl);
    return (32'(pc) << TLW) | 32'(tl);
  endfunction

  task automatic arm(input int pc, input int tl, input int mp);
    wr(2'd2, len_word(pc, tl));
    wr(2'd0, 32'h8000_0000 | 32'(mp));
  endtask

  task automatic load(input int sz);
    @(posedge clk); #1; pkt_wr = 1'b1; pkt_size = MPLW'(sz);
    @(posedge clk); #1; pkt_wr = 1'b0;
  endtask

  task automatic token(input bit expect_go);
    exp_q.push_back(expect_go);
    @(posedge clk); #1; in_tok = 1'b1;
    @(posedge clk); #1; in_tok = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic finish_txn(input bit ack);
    @(posedge clk); #1; txn_done = 1'b1; txn_ack = ack;
    @(posedge clk); #1; txn_done = 1'b0; txn_ack = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    #2;
    check("R1 irq", 32'(irq), 0);
    check("R1 tx", 32'({tx_go, tx_nak}), 0);
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd2, d); check("R1 len", d, 0);
    rd(2'd3, d); check("R1 flags", d, 0);
    rd(2'd1, d); check("R1 ien", d, 0);

    // Three packets: 64, 64, 10
    arm(3, 138, 64);
    rd(2'd0, d); check("R2 ctrl", d, 32'h8000_0040);
    check("R3 first size", 32'(next_pkt_size), 64);
    token(1'b0); // R7: nothing loaded
    rd(2'd3, d); check("R7 nak flag", d & 32'h8, 32'h8);
    rd(2'd2, d); check("R7 len unchanged", d, len_word(3, 138));
    wr(2'd3, 32'h1F);
    load(64);
    rd(2'd2, d); check("R5 tlen", d & 32'h7FFFF, 74);
    token(1'b1);
    finish_txn(1'b1);
    rd(2'd2, d); check("R6 pcnt", d >> TLW, 2);
    rd(2'd3, d); check("R6 ack flag", d & 32'h1, 32'h1);
    check("R3 middle size", 32'(next_pkt_size), 64);
    load(64); token(1'b1); finish_txn(1'b1);
    check("R3 last size", 32'(next_pkt_size), 10);
    load(10); token(1'b1); finish_txn(1'b1);
    rd(2'd3, d); check("R9 done flag", (d >> 1) & 1, 1);
    rd(2'd0, d); check("R9 auto disable", d >> 31, 0);
    rd(2'd2, d); check("R9 len zero", d, 0);

    // R11 interrupt masking and W1C
    check("R11 masked irq", 32'(irq), 0);
    wr(2'd1, 32'h2);
    repeat (2) @(posedge clk); #1;
    check("R11 irq set", 32'(irq), 1);
    wr(2'd3, 32'h1F);
    repeat (2) @(posedge clk); #1;
    check("R11 irq clear", 32'(irq), 0);
    rd(2'd3, d); check("R11 w1c flags", d, 0);
    wr(2'd1, 32'h0);

    // R4 zero-length packet
    arm(1, 0, 64);
    check("R4 zlp size", 32'(next_pkt_size), 0);
    load(0); token(1'b1); finish_txn(1'b1);
    rd(2'd3, d); check("R4 zlp done", (d >> 1) & 1, 1);
    check("R4 disabled", 32'(ep_active), 0);
    wr(2'd3, 32'h1F);

    // R8 failed transaction
    arm(2, 100, 64);
    load(64); token(1'b1); finish_txn(1'b0);
    rd(2'd3, d); check("R8 txerr flag", (d >> 2) & 1, 1);
    rd(2'd2, d); check("R8 pcnt dec", d >> TLW, 1);
    check("R3 remainder", 32'(next_pkt_size), 36);
    wr(2'd3, 32'h1F);
    load(36); token(1'b1); finish_txn(1'b1);
    rd(2'd3, d); check("R8 no done", (d >> 1) & 1, 0);
    check("R8 disabled", 32'(ep_active), 0);
    wr(2'd3, 32'h1F);

    // R12 size mismatch
    arm(2, 100, 64);
    load(50);
    rd(2'd3, d); check("R12 size err", (d >> 4) & 1, 1);
    wr(2'd3, 32'h1F);

    // R3 single packet, R10 software disable
    arm(1, 20, 64);
    check("R3 single size", 32'(next_pkt_size), 20);
    load(20);
    wr(2'd0, 32'h0000_0040);
    check("R10 disabled", 32'(ep_active), 0);
    token(1'b0);
    rd(2'd2, d); check("R10 len kept", d, len_word(1, 0));
    wr(2'd3, 32'h1F);

    // R12 inconsistent length word
    arm(2, 200, 64);
    rd(2'd0, d); check("R12 arm refused", d >> 31, 0);
    rd(2'd3, d); check("R12 cfg err", (d >> 4) & 1, 1);

    repeat (4) @(posedge clk);
    check("R6 queue drained", 32'(exp_q.size()), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule